// File: doc/BRIEF.md
# SPI Command Frame Front End

This block is the slave side of a full-duplex serial link that carries fixed 16-bit words. It brings the serial clock, the active-low select and the serial data input into the system clock domain. While the block is selected it shifts the incoming command in and the outgoing reply out, both most significant bit first. A command is accepted only if the select-low period held a whole, nonzero number of 16-clock words. Each accepted command is handed to core logic as a one-cycle strobe. The strobe carries the command word and a flag that says whether its opcode is one the block recognises.

The reply to a command is sent in the next frame. When select falls, core logic presents the reply on `rsp_i` and the block loads it into the output shift register. If the previous accepted command was undefined, the block loads a fixed placeholder word instead. The block never loads the all-ones word, so a host that reads all ones knows the data-out line is floating. The serial clock idles low, the block captures data on its rising edge and changes its output on its falling edge. The system clock must run at least four times the serial clock rate.

Top module: `spi_cmd_frontend`

## Requirements
- R1: During and straight after reset, `so_oe_o`, `cmd_valid_o` and `cmd_o` are all zero.
- R2: `so_oe_o` is high while the block is selected (`csb_i` low, seen after synchronisation) and low otherwise. While it is low, `so_o` is 0.
- R3: Bits on `si_i` are captured at rising `sck_i` edges, most significant bit first. For a 16-clock frame, `cmd_o` equals the 16 captured bits.
- R4: The most significant bit of the loaded reply is on `so_o` before the first rising `sck_i` edge. `so_o` advances one bit after each falling edge and holds steady across rising edges.
- R5: A frame is accepted only when the number of rising `sck_i` edges while selected is a nonzero multiple of 16. A rejected frame gives no strobe and changes no state, including the reply choice for the next frame.
- R6: An accepted frame gives `cmd_valid_o` high for exactly one cycle after `csb_i` rises. `cmd_defined_o` is bit `cmd_o[15:12]` of `OPCODE_MAP`. By default the defined opcodes are 1, 2, 4, 5, 6, 7 and 9.
- R7: On select falling, the reply shift register is loaded from `rsp_i`. If the last accepted command was undefined, it is loaded with `UNDEF_RSP` instead (default 16'hE0E0).
- R8: 16'hFFFF is never loaded. If `rsp_i` is 16'hFFFF, 16'hFFFE is loaded in its place.
- R9: In a frame of 32 or more clocks, the last 16 bits received form the command. After the 16 reply bits, `so_o` sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, idle low |
| csb_i | input | 1 | Active-low select |
| si_i | input | 1 | Serial data in |
| rsp_i | input | 16 | Reply word from core logic, loaded on select fall |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the data-out pad |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_o | output | 16 | Accepted command word |
| cmd_defined_o | output | 1 | Opcode of `cmd_o` is defined |

## Verification
The bench sends frames with zero clocks, 15 clocks and 17 clocks. A block that does not check the edge count would strobe out a torn command on these, or would clear its record of an undefined command. One sequence sends an undefined opcode, then a rejected frame, then a good one. A design that lets the rejected frame change state would send `rsp_i` in that last frame instead of the placeholder. The bench also sends a reply of all ones, which a design without the guard would shift out unchanged. It sends frames of 32 and 48 clocks, where a design that keeps the first word, or that sends the reply over again, would show up in `cmd_o` or in the trailing bits on `so_o`.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned OPC_W     = 4;
  localparam int unsigned BIT_CNT_W = $clog2(WORD_W);
  localparam int unsigned MAP_W     = 2 ** OPC_W;
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t ALL_ONES   = '1;
  localparam word_t ONES_SUBST = ALL_ONES - word_t'(1);
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int unsigned N_SIG = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SIG-1:0] async_i,
  output logic [N_SIG-1:0] sync_o
);
  for (genvar g = 0; g < N_SIG; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
    end
    assign sync_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
  import spi_fe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  sel_i,
  input  logic  sck_rise_i,
  input  logic  sck_fall_i,
  input  logic  si_i,
  input  word_t load_word_i,
  output logic  so_bit_o,
  output word_t rx_word_o,
  output word_t tx_word_o,
  output logic  frame_ok_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

  word_t rx_q, tx_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic word_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q        <= '0;
      tx_q        <= '0;
      cnt_q       <= '0;
      word_seen_q <= 1'b0;
    end else if (start_i) begin
      tx_q        <= load_word_i;
      cnt_q       <= '0;
      word_seen_q <= 1'b0;
    end else if (sel_i) begin
      if (sck_rise_i) begin
        rx_q  <= {rx_q[WORD_W-2:0], si_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) word_seen_q <= 1'b1;
      end
      if (sck_fall_i) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  // whole words only: counter wrapped at least once and sits at zero
  assign frame_ok_o = word_seen_q && (cnt_q == '0);
  assign so_bit_o   = tx_q[WORD_W-1];
  assign rx_word_o  = rx_q;
  assign tx_word_o  = tx_q;
endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
  import spi_fe_pkg::*;
#(
  parameter logic [MAP_W-1:0] OPCODE_MAP = 16'h02F6
) (
  input  word_t word_i,
  output logic  defined_o
);
  logic [OPC_W-1:0] opc;
  assign opc       = word_i[WORD_W-1 -: OPC_W];
  assign defined_o = OPCODE_MAP[opc];
endmodule

// File: rtl/spi_fe_reply.sv
module spi_fe_reply
  import spi_fe_pkg::*;
#(
  parameter word_t UNDEF_RSP = 16'hE0E0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  accept_i,
  input  logic  defined_i,
  input  word_t rsp_i,
  output word_t load_word_o
);
  logic undef_pend_q;
  word_t pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       undef_pend_q <= 1'b0;
    else if (accept_i) undef_pend_q <= ~defined_i;
  end

  assign pick        = undef_pend_q ? UNDEF_RSP : rsp_i;
  // all-ones is reserved for a floating line
  assign load_word_o = (pick == ALL_ONES) ? ONES_SUBST : pick;
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [MAP_W-1:0] OPCODE_MAP = 16'h02F6,
  parameter word_t UNDEF_RSP = 16'hE0E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csb_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] rsp_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_defined_o
);
  logic [2:0] sync_w;
  logic csb_s, sck_s, si_s;
  logic csb_prev_q, sck_prev_q;
  logic csb_rise, csb_fall, sck_rise, sck_fall, sel;
  logic frame_ok, rx_defined, accept, so_bit;
  word_t rx_word, tx_word, load_word;
  logic cmd_valid_q, cmd_def_q;
  word_t cmd_q;

  spi_fe_sync #(.N_SIG(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .async_i({csb_i, sck_i, si_i}), .sync_o(sync_w)
  );
  assign {csb_s, sck_s, si_s} = sync_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csb_prev_q <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      csb_prev_q <= csb_s;
      sck_prev_q <= sck_s;
    end
  end

  assign csb_rise = csb_s & ~csb_prev_q;
  assign csb_fall = ~csb_s & csb_prev_q;
  assign sck_rise = sck_s & ~sck_prev_q;
  assign sck_fall = ~sck_s & sck_prev_q;
  assign sel      = ~csb_s;

  spi_fe_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(csb_fall), .sel_i(sel),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .si_i(si_s),
    .load_word_i(load_word), .so_bit_o(so_bit),
    .rx_word_o(rx_word), .tx_word_o(tx_word), .frame_ok_o(frame_ok)
  );

  spi_fe_decode #(.OPCODE_MAP(OPCODE_MAP)) u_dec (
    .word_i(rx_word), .defined_o(rx_defined)
  );

  assign accept = csb_rise & frame_ok;

  spi_fe_reply #(.UNDEF_RSP(UNDEF_RSP)) u_reply (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .accept_i(accept), .defined_i(rx_defined),
    .rsp_i(rsp_i), .load_word_o(load_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_q       <= '0;
      cmd_def_q   <= 1'b0;
    end else begin
      cmd_valid_q <= accept;
      if (accept) begin
        cmd_q     <= rx_word;
        cmd_def_q <= rx_defined;
      end
    end
  end

  assign so_oe_o       = sel;
  assign so_o          = so_bit & sel;
  assign cmd_valid_o   = cmd_valid_q;
  assign cmd_o         = cmd_q;
  assign cmd_defined_o = cmd_def_q;
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk
  import spi_fe_pkg::*;
#(
  parameter logic [MAP_W-1:0] OPCODE_MAP = 16'h02F6
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  so_o,
  input logic  so_oe_o,
  input logic  cmd_valid_o,
  input logic  cmd_defined_o,
  input word_t cmd_o,
  input logic  csb_rise_i,
  input logic  csb_fall_i,
  input logic  sck_rise_i,
  input word_t tx_word_i
);
  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_decode_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_defined_o == OPCODE_MAP[cmd_o[WORD_W-1 -: OPC_W]]));

  p_strobe_after_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> ($past(csb_rise_i) && !so_oe_o));

  p_no_ones_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_fall_i |=> (tx_word_i != ALL_ONES));

  p_so_hold_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_rise_i && so_oe_o) |=> ($stable(so_o) || !so_oe_o));

  p_so_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_o |-> !so_o);
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.OPCODE_MAP(OPCODE_MAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .so_o(so_o), .so_oe_o(so_oe_o),
  .cmd_valid_o(cmd_valid_o), .cmd_defined_o(cmd_defined_o), .cmd_o(cmd_o),
  .csb_rise_i(csb_rise), .csb_fall_i(csb_fall), .sck_rise_i(sck_rise),
  .tx_word_i(tx_word)
);

// File: tb/spi_cmd_frontend_tb_top.sv
module spi_cmd_frontend_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csb = 1'b1, si = 1'b0;
  logic [15:0] rsp = '0;
  logic so, so_oe, cmd_valid, cmd_def;
  logic [15:0] cmd;
  int total = 0, bad = 0;
  bit done = 0;
  bit pend = 0;

  always #2 clk = ~clk;

  spi_cmd_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csb_i(csb), .si_i(si),
    .rsp_i(rsp), .so_o(so), .so_oe_o(so_oe), .cmd_valid_o(cmd_valid),
    .cmd_o(cmd), .cmd_defined_o(cmd_def)
  );

  function automatic bit is_def(input logic [3:0] op);
    return op inside {4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic frame(input int nbits, input logic [63:0] mosi, input logic [15:0] r);
    logic [15:0] exp_load;
    logic [63:0] miso, exp_m, tmp;
    logic [15:0] got_cmd;
    logic got_def;
    int nvalid;
    bit acc;
    rsp = r;
    exp_load = pend ? 16'hE0E0 : ((r == 16'hFFFF) ? 16'hFFFE : r);
    miso = '0; got_cmd = '0; got_def = 1'b0; nvalid = 0;
    @(negedge clk) csb = 1'b0;
    repeat (6) @(negedge clk);
    check(so_oe == 1'b1, "R2", "oe selected", 64'(so_oe), 64'd1);
    for (int i = 0; i < nbits; i++) begin
      si = mosi[nbits-1-i];
      repeat (5) @(negedge clk);
      miso[nbits-1-i] = so;
      sck = 1'b1;
      repeat (5) @(negedge clk);
      sck = 1'b0;
    end
    repeat (5) @(negedge clk);
    csb = 1'b1; si = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (cmd_valid) begin
        nvalid++; got_cmd = cmd; got_def = cmd_def;
      end
    end
    check(so_oe == 1'b0 && so == 1'b0, "R2", "oe idle", {so_oe, so}, 64'd0);
    if (nbits > 0) begin
      tmp = {exp_load, 48'd0};
      exp_m = tmp >> (64 - nbits);
      check(miso == exp_m, (nbits > 16) ? "R9" : "R4", "miso stream", miso, exp_m);
      if (nbits >= 16)
        check(miso[nbits-1 -: 16] == exp_load, (r == 16'hFFFF && !pend) ? "R8" : "R7",
              "loaded reply", 64'(miso[nbits-1 -: 16]), 64'(exp_load));
    end
    acc = (nbits > 0) && (nbits % 16 == 0);
    if (acc) begin
      check(nvalid == 1, "R6", "strobe count", 64'(nvalid), 64'd1);
      check(got_cmd == mosi[15:0], (nbits > 16) ? "R9" : "R3", "command",
            64'(got_cmd), 64'(mosi[15:0]));
      check(got_def == is_def(mosi[15:12]), "R6", "defined flag",
            64'(got_def), 64'(is_def(mosi[15:12])));
      pend = !is_def(mosi[15:12]);
    end else begin
      check(nvalid == 0, "R5", "rejected frame strobe", 64'(nvalid), 64'd0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int lens[8] = '{8, 15, 16, 16, 16, 32, 33, 48};
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(so_oe == 0 && cmd_valid == 0 && cmd == 0, "R1", "in reset",
          {so_oe, cmd_valid, cmd}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(so_oe == 0 && cmd_valid == 0 && cmd == 0, "R1", "after reset",
          {so_oe, cmd_valid, cmd}, 64'd0);
    frame(16, 64'h1234, 16'hA5A5);          // R3 defined opcode
    frame(16, 64'h3000, 16'h1111);          // R6 undefined opcode
    frame(16, 64'h2ABC, 16'h5555);          // R7 placeholder reply
    frame(16, 64'h4000, 16'hFFFF);          // R8 all-ones guard
    frame(0, 64'h0, 16'h0F0F);              // R5 no clocks
    frame(15, 64'h7FFF, 16'h0F0F);          // R5 short
    frame(16, 64'hF00D, 16'h2222);          // undefined again
    frame(17, 64'h1_2345, 16'h3333);        // R5 rejected keeps pending
    frame(16, 64'h9001, 16'h4444);          // expect placeholder
    frame(32, 64'hDEAD_5678, 16'h6666);     // R9 last word wins
    frame(48, 64'h1111_2222_6ABC, 16'hFFFF);
    for (int n = 0; n < 30; n++) begin
      frame(lens[$urandom_range(0, 7)], {$urandom, $urandom}, 16'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule